// File: doc/BRIEF.md
# Single-Access Unaligned Word Memory

This block is a byte-addressed storage array that serves a full 32-bit word starting at any byte address in one access. The storage is split into four banks, each one byte wide, so that each bank holds one byte lane of the 32-bit data path. The upper address bits form a row index that all banks share. The two low address bits give the start offset inside the row. A bank whose lane falls below that offset is driven with the row index plus one. The requested bytes can then come from two neighbouring rows in the same cycle.

A rotation network sits on each side of the banks. On the way in, it moves write data and byte enables from request order into bank order. On the way out, it puts the bank outputs back into request order, so result byte 0 is always the byte at the requested address (little-endian). If an unaligned access starts in the last row, the second row it needs does not exist. Such an access is refused: it writes nothing, returns zero data and raises an error flag with its response.

Top module: `byte_bank_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_valid` and `rsp_err` are 0. `rsp_err` is never 1 while `rsp_valid` is 0.
- R2: Every request cycle (`req_valid`=1) gives exactly one response cycle (`rsp_valid`=1) on the next clock edge. A cycle without a request gives no response on the next edge.
- R3: A read at an address whose two low bits are 00 returns bytes A, A+1, A+2, A+3 in result bits [7:0], [15:8], [23:16] and [31:24].
- R4: A read at an address whose two low bits are 01, 10 or 11 returns the same little-endian arrangement of bytes A..A+3, including bytes from the next row, in a single response.
- R5: A write stores byte k of `req_wdata` (bits 8k+7:8k) at address A+k when `req_be[k]` is 1. Bytes whose enable bit is 0 keep their old contents.
- R6: A write at an unaligned address whose bytes cross into the next row updates both rows in one request, with the same byte-enable rule as R5.
- R7: An access whose row is the last row and whose two low address bits are not 00 gives `rsp_err`=1 and `rsp_rdata`=0. If it is a write, it changes no stored byte.
- R8: An access at address bits [1:0]=00 in the last row is served normally with `rsp_err`=0.
- R9: The response to a write, and the response to any refused access, carries `rsp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the response state |
| req_valid | input | 1 | A request is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (8) | Byte address of the first byte of the word |
| req_wdata | input | 32 | Write data, byte k goes to address A+k |
| req_be | input | 4 | Byte enables, bit k qualifies write byte k |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | 32 | Read data, byte k is the byte at address A+k |
| rsp_err | output | 1 | The previous request ran past the last row and was refused |

## Verification
The hardest case to reach from the ports is a write that crosses a row boundary with a sparse byte-enable pattern, followed at once by a read that crosses the same boundary from a different offset. In that case bank-row selection and lane rotation must agree on both sides of the banks. The stimulus fills the whole array with a known pattern and then issues misaligned partial writes at every offset. Reads follow back-to-back at shifted offsets, so that every bank is seen both on the row and on the row-plus-one path. The refused accesses at the top row are then checked for side effects with aligned reads of that row.

// File: rtl/byte_bank_pkg.sv
// Package: shared sizing helpers for the byte-banked memory.
// Assumes the lane count is a power of two so lane offsets wrap naturally.
package byte_bank_pkg;

    localparam int unsigned BYTE_W = 8;

    // Number of bits needed to index n items, at least 1.
    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/bank_row_sel.sv
// bank_row_sel: gives each byte bank its row index. It also flags a request
// that would need a row past the end of the array.
// Assumes: lane b belongs to the next row exactly when b < start offset.
module bank_row_sel
    import byte_bank_pkg::*;
#(
    parameter int unsigned ROWS  = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned ROW_W = idx_bits(ROWS),
    localparam int unsigned OFS_W = idx_bits(LANES)
) (
    input  logic [ROW_W-1:0] row_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [ROW_W-1:0] bank_row_o [LANES],
    output logic             wrap_err_o
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_next;

    // Next row index, shared by all lanes that lie below the start offset.
    always_comb begin
        row_next = row_i + ROW_W'(1);
    end

    // Refuse an unaligned request whose second row does not exist.
    always_comb begin
        wrap_err_o = (ofs_i != '0) && (row_i == LAST_ROW);
    end

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        localparam logic [OFS_W-1:0] LANE_ID = OFS_W'(b);
        // Per-lane increment select.
        always_comb begin
            bank_row_o[b] = (LANE_ID < ofs_i) ? row_next : row_i;
        end
    end

endmodule

// File: rtl/lane_rotate.sv
// lane_rotate: rotates LANES fields of width W by a lane offset.
// TO_BANKS=1: request lane k moves to bank lane (k+ofs) mod LANES.
// TO_BANKS=0: result lane k is taken from bank lane (k+ofs) mod LANES.
// Assumes a power-of-two lane count; offset arithmetic wraps in OFS_W bits.
module lane_rotate
    import byte_bank_pkg::*;
#(
    parameter int unsigned LANES    = 4,
    parameter int unsigned W        = 8,
    parameter bit          TO_BANKS = 1'b1,
    localparam int unsigned OFS_W   = idx_bits(LANES)
) (
    input  logic [LANES*W-1:0] din_i,
    input  logic [OFS_W-1:0]   ofs_i,
    output logic [LANES*W-1:0] dout_o
);

    for (genvar d = 0; d < LANES; d++) begin : g_lane
        localparam logic [OFS_W-1:0] DST = OFS_W'(d);
        logic [OFS_W-1:0] src;

        // Source lane for this destination, direction picked by parameter.
        if (TO_BANKS) begin : g_fwd
            always_comb src = DST - ofs_i;
        end else begin : g_back
            always_comb src = DST + ofs_i;
        end

        // Lane multiplexer.
        always_comb begin
            dout_o[d*W +: W] = din_i[src*W +: W];
        end
    end

endmodule

// File: rtl/byte_bank.sv
// byte_bank: one byte-wide synchronous single-port storage bank.
// A read returns data one cycle after an enabled non-write access.
// Assumes no reset of stored contents (storage array).
module byte_bank
    import byte_bank_pkg::*;
#(
    parameter int unsigned ROWS = 64,
    parameter int unsigned W    = BYTE_W,
    localparam int unsigned ROW_W = idx_bits(ROWS)
) (
    input  logic             clk,
    input  logic             en_i,
    input  logic             we_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [W-1:0]     wdata_i,
    output logic [W-1:0]     rdata_o
);

    logic [W-1:0] store [ROWS];

    // Write the byte, or read it into the output register.
    always_ff @(posedge clk) begin
        if (en_i) begin
            if (we_i) begin
                store[row_i] <= wdata_i;
            end else begin
                rdata_o <= store[row_i];
            end
        end
    end

endmodule

// File: rtl/byte_bank_mem.sv
// byte_bank_mem: byte-addressed memory returning or writing a LANES-byte
// word at any byte address in one access, using per-bank row increment.
// Assumes requests are accepted every cycle; response follows one cycle later.
module byte_bank_mem
    import byte_bank_pkg::*;
#(
    parameter int unsigned ROWS  = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned ROW_W  = idx_bits(ROWS),
    localparam int unsigned OFS_W  = idx_bits(LANES),
    localparam int unsigned ADDR_W = ROW_W + OFS_W,
    localparam int unsigned DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    logic [ROW_W-1:0]  row;
    logic [OFS_W-1:0]  ofs;
    logic [ROW_W-1:0]  bank_row [LANES];
    logic              wrap_err;
    logic              access_ok;
    logic [DATA_W-1:0] bank_wdata;
    logic [LANES-1:0]  bank_be;
    logic [DATA_W-1:0] bank_rdata;
    logic [DATA_W-1:0] rot_rdata;

    logic              valid_q;
    logic              err_q;
    logic              rd_q;
    logic [OFS_W-1:0]  ofs_q;

    // Split the byte address into the shared row and the start offset.
    always_comb begin
        row = req_addr[ADDR_W-1:OFS_W];
        ofs = req_addr[OFS_W-1:0];
    end

    bank_row_sel #(.ROWS(ROWS), .LANES(LANES)) row_sel_i (
        .row_i      (row),
        .ofs_i      (ofs),
        .bank_row_o (bank_row),
        .wrap_err_o (wrap_err)
    );

    // A request touches the banks only if it stays inside the array.
    always_comb begin
        access_ok = req_valid && !wrap_err;
    end

    lane_rotate #(.LANES(LANES), .W(BYTE_W), .TO_BANKS(1'b1)) wdata_rot_i (
        .din_i  (req_wdata),
        .ofs_i  (ofs),
        .dout_o (bank_wdata)
    );

    lane_rotate #(.LANES(LANES), .W(1), .TO_BANKS(1'b1)) be_rot_i (
        .din_i  (req_be),
        .ofs_i  (ofs),
        .dout_o (bank_be)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic bank_en;
        logic bank_we;

        // Enable a bank for reads, or for writes only on its enabled lane.
        always_comb begin
            bank_we = req_write && bank_be[b];
            bank_en = access_ok && (!req_write || bank_be[b]);
        end

        byte_bank #(.ROWS(ROWS), .W(BYTE_W)) bank_i (
            .clk     (clk),
            .en_i    (bank_en),
            .we_i    (bank_we),
            .row_i   (bank_row[b]),
            .wdata_i (bank_wdata[b*BYTE_W +: BYTE_W]),
            .rdata_o (bank_rdata[b*BYTE_W +: BYTE_W])
        );
    end

    // Register the response control next to the bank read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            rd_q    <= 1'b0;
            ofs_q   <= '0;
        end else begin
            valid_q <= req_valid;
            err_q   <= req_valid && wrap_err;
            rd_q    <= access_ok && !req_write;
            ofs_q   <= ofs;
        end
    end

    lane_rotate #(.LANES(LANES), .W(BYTE_W), .TO_BANKS(1'b0)) rdata_rot_i (
        .din_i  (bank_rdata),
        .ofs_i  (ofs_q),
        .dout_o (rot_rdata)
    );

    // Drive the response; data only for a served read.
    always_comb begin
        rsp_valid = valid_q;
        rsp_err   = err_q;
        rsp_rdata = rd_q ? rot_rdata : '0;
    end

endmodule

// File: rtl/byte_bank_mem_chk.sv
// byte_bank_mem_chk: port-level temporal checks for byte_bank_mem,
// attached with bind below.
module byte_bank_mem_chk
    import byte_bank_pkg::*;
#(
    parameter int unsigned ROWS  = 64,
    parameter int unsigned LANES = 4,
    localparam int unsigned ROW_W  = idx_bits(ROWS),
    localparam int unsigned OFS_W  = idx_bits(LANES),
    localparam int unsigned ADDR_W = ROW_W + OFS_W,
    localparam int unsigned DATA_W = LANES * BYTE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    // R1
    err_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_err);

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R7
    wrap_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[ADDR_W-1:OFS_W] == LAST_ROW
         && req_addr[OFS_W-1:0] != '0) |=> (rsp_err && rsp_rdata == '0));

    // R8
    aligned_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[OFS_W-1:0] == '0) |=> !rsp_err);

    // R9
    write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == '0));

endmodule

bind byte_bank_mem byte_bank_mem_chk #(.ROWS(ROWS), .LANES(LANES)) chk_i (.*);

// File: tb/byte_bank_mem_tb_top.sv
// Scoreboard bench: the driver computes expected responses from a byte
// model and queues them; the monitor compares each response as it appears.
module byte_bank_mem_tb_top;

    localparam int ROWS  = 64;
    localparam int LANES = 4;
    localparam int NBYTE = ROWS * LANES;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    typedef struct {
        logic [31:0] data;
        bit          err;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [7:0]  model [NBYTE];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    byte_bank_mem #(.ROWS(ROWS), .LANES(LANES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Driver: present one request and queue its expected response.
    task automatic issue(input bit wr, input int addr, input logic [31:0] wd,
                         input logic [3:0] be, input string tag);
        exp_t e;
        bit   wrap;
        wrap = ((addr / LANES) == ROWS - 1) && ((addr % LANES) != 0);
        e.err = wrap;
        e.tag = wrap ? {tag, "/R7"} : tag;
        e.data = '0;
        if (!wrap) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr) begin
                    if (be[k]) model[addr + k] = wd[8*k +: 8];
                end else begin
                    e.data[8*k +: 8] = model[addr + k];
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = 8'(addr);
        req_wdata = wd;
        req_be    = be;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            req_write = 1'b0;
        end
    endtask

    // Monitor: compare every response with the head of the scoreboard (R2).
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2 unexpected response", 64'(rsp_rdata), 64'(0));
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(rsp_rdata == e.data, {e.tag, " data"}, 64'(rsp_rdata), 64'(e.data));
                    check(rsp_err == e.err, {e.tag, " err"}, 64'(rsp_err), 64'(e.err));
                end
            end else if (rst_n && !rsp_valid && sb_q.size() != 0) begin
                check(1'b0, "R2 missing response", 64'(0), 64'(1));
                void'(sb_q.pop_front());
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 in reset", 64'({rsp_valid, rsp_err}), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 after reset", 64'({rsp_valid, rsp_err}), 64'(0));

        // R5: fill every row with aligned full writes.
        for (int r = 0; r < ROWS; r++) begin
            issue(1'b1, r * 4, {8'(4*r+3), 8'(4*r+2), 8'(4*r+1), 8'(4*r)} ^ 32'hA5C3_5A3C, 4'hF, "R5 fill");
        end
        idle(2);

        // R3: aligned reads.
        for (int r = 0; r < ROWS; r += 7) issue(1'b0, r * 4, '0, '0, "R3 aligned read");
        idle(1);

        // R4: unaligned reads at every offset, back to back.
        for (int a = 1; a < 40; a++) begin
            if (a % 4 != 0) issue(1'b0, a, '0, '0, "R4 unaligned read");
        end
        idle(2);

        // R6: unaligned partial writes crossing rows, then reads at other offsets.
        issue(1'b1, 9,  32'h1122_3344, 4'b1010, "R6 write ofs1");
        issue(1'b0, 8,  '0, '0, "R6 readback");
        issue(1'b0, 10, '0, '0, "R6 readback");
        issue(1'b1, 22, 32'hDEAD_BEEF, 4'b1101, "R6 write ofs2");
        issue(1'b0, 21, '0, '0, "R6 readback");
        issue(1'b0, 24, '0, '0, "R6 readback");
        issue(1'b1, 35, 32'hCAFE_F00D, 4'b0110, "R6 write ofs3");
        issue(1'b0, 33, '0, '0, "R6 readback");
        issue(1'b0, 36, '0, '0, "R6 readback");
        issue(1'b1, 45, 32'h0102_0304, 4'b0000, "R5 no-enable write");
        issue(1'b0, 44, '0, '0, "R5 readback");
        issue(1'b0, 48, '0, '0, "R5 readback");
        idle(2);

        // R7/R8: last-row boundary.
        issue(1'b1, 255, 32'hFFFF_FFFF, 4'hF, "R7 wrap write");
        issue(1'b1, 253, 32'h7777_7777, 4'hF, "R7 wrap write");
        issue(1'b0, 254, '0, '0, "R7 wrap read");
        issue(1'b0, 252, '0, '0, "R8 last row aligned read");
        issue(1'b1, 252, 32'h0BAD_F00D, 4'b0101, "R8 last row aligned write");
        issue(1'b0, 252, '0, '0, "R8 readback");
        issue(1'b0, 249, '0, '0, "R4 into last row");
        idle(3);

        // R9 and mixed traffic.
        for (int i = 0; i < 400; i++) begin
            int a;
            bit w;
            a = int'($urandom_range(0, NBYTE - 1));
            w = ($urandom_range(0, 2) == 0);
            issue(w, a, $urandom(), 4'($urandom()), w ? "R9 mixed write" : "R4 mixed read");
            if (i % 37 == 0) idle(1);
        end
        idle(4);
        check(sb_q.size() == 0, "R2 drained", 64'(sb_q.size()), 64'(0));
        finish_run();
    end

endmodule